// File: doc/BRIEF.md
# Pixel Output Formatter

This block sits between a 12-bit pixel converter and the device's parallel output pins. Each clock it takes one sample, along with the current levels of three strobes. The output-latch strobe says when the output register loads. The black-clamp strobe marks optical-black pixels. The blanking strobe marks pixels that must not reach the output. The sample and its two pixel-marking flags move together through a fixed-length delay line. At the end of that line the sample is replaced with a blank value if required, and is optionally converted to Gray code. The result then goes to the pins, either through a register loaded by the latch strobe or directly.

A small state machine sets how the pins are driven. In `S_LATCH` the pins show the output register. In `S_PASS` they show the formatted value directly. In `S_FLOAT` the output enable is low and the data is parked at zero. The state register loads every clock, and its next state comes from the configuration inputs in a fixed order. `T_TO_FLOAT`: a float request moves the machine to `S_FLOAT` from any state. `T_TO_PASS`: with no float request, a transparency request moves it to `S_PASS`. `T_TO_LATCH`: with neither request, it moves to `S_LATCH`. Reset places the machine in `S_LATCH`.

Top module: `pix_formatter`

## Requirements
- R1: While reset is held, and straight after it, `pix_out` is 0 and `pix_oe` is 1.
- R2: In the latched mode, with the latch strobe active on every clock, a sample presented before clock edge k appears on `pix_out` after edge k+LAT-1. That is a latency of LAT clock edges, with LAT defaulting to 10.
- R3: In the transparent mode (`cfg_transparent`=1), a sample appears one edge earlier than in R2, after edge k+LAT-2.
- R4: In the latched mode, the output register loads only on edges where the latch strobe is active. On other edges `pix_out` holds its value.
- R5: Each strobe counts as active when its raw level equals its polarity bit: 1 means active high and 0 means active low. Polarity is applied at the input, so a flag keeps the meaning it had when its sample entered.
- R6: A sample whose blanking flag is active and whose clamp flag is inactive comes out as 0 when `cfg_blank_sel`=0.
- R7: With `cfg_blank_sel`=1, a blanked sample comes out as `cfg_clamp_lvl`, zero-extended into the low 8 bits.
- R8: A sample whose clamp flag is active passes through unchanged, whatever the state of its blanking flag.
- R9: With `cfg_gray`=1, the output is g = b ^ (b >> 1), where b is the value after any blank substitution.
- R10: With `cfg_tristate`=1, `pix_oe` is 0 and `pix_out` is 0. Changes to the mode bits show on the first output sampled after the edge at which the bits are seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | DW | Converter sample |
| dclk_in | input | 1 | Raw output-latch strobe |
| clamp_in | input | 1 | Raw black-clamp strobe |
| blank_in | input | 1 | Raw blanking strobe |
| cfg_pol_dclk | input | 1 | Latch strobe polarity (1 = active high) |
| cfg_pol_clamp | input | 1 | Clamp strobe polarity (1 = active high) |
| cfg_pol_blank | input | 1 | Blanking strobe polarity (1 = active high) |
| cfg_blank_sel | input | 1 | Blank value: 0 = zero, 1 = clamp level |
| cfg_gray | input | 1 | 1 = Gray-coded output |
| cfg_transparent | input | 1 | 1 = bypass the output register |
| cfg_tristate | input | 1 | 1 = release the output bus |
| cfg_clamp_lvl | input | CLW | Programmed black level |
| pix_out | output | DW | Output data bus |
| pix_oe | output | 1 | Output enable for the data bus |

## Verification
The bench builds two copies of the block from one stimulus stream. One uses the default LAT=10. The other uses LAT=2, the shortest allowed, where the delay line is a single register and the shift-register variant is not generated. The two latencies expose off-by-one errors in the flag alignment and in the latched and transparent outputs at both extremes. A behavioural model compares both copies against a history of presented samples on every clock.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
    typedef enum logic [1:0] {
        S_LATCH = 2'd0,
        S_PASS  = 2'd1,
        S_FLOAT = 2'd2
    } drive_state_t;

    localparam int STB_DCLK  = 0;
    localparam int STB_CLAMP = 1;
    localparam int STB_BLANK = 2;
    localparam int STB_COUNT = 3;
endpackage

// File: rtl/pxf_strobe_pol.sv
module pxf_strobe_pol #(
    parameter int N = 3
) (
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol,
    output logic [N-1:0] act
);
    for (genvar i = 0; i < N; i++) begin : g_stb
        assign act[i] = pol[i] ? raw[i] : ~raw[i];
    end
endmodule

// File: rtl/pxf_delay.sv
module pxf_delay #(
    parameter int DW     = 12,
    parameter int STAGES = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_data,
    input  logic          in_blank,
    input  logic          in_clamp,
    output logic [DW-1:0] out_data,
    output logic          out_blank,
    output logic          out_clamp
);
    localparam int W = DW + 2;

    logic [STAGES-1:0][W-1:0] stg;

    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= '0;
            else        stg <= {in_blank, in_clamp, in_data};
        end
    end else begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[STAGES-2:0], {in_blank, in_clamp, in_data}};
        end
    end

    assign out_data  = stg[STAGES-1][DW-1:0];
    assign out_clamp = stg[STAGES-1][DW];
    assign out_blank = stg[STAGES-1][DW+1];
endmodule

// File: rtl/pxf_former.sv
module pxf_former #(
    parameter int DW  = 12,
    parameter int CLW = 8
) (
    input  logic [DW-1:0]  data,
    input  logic           blank,
    input  logic           clamp,
    input  logic           blank_sel,
    input  logic           gray,
    input  logic [CLW-1:0] clamp_lvl,
    output logic [DW-1:0]  value
);
    logic [DW-1:0] lvl_ext;
    logic [DW-1:0] sub;

    assign lvl_ext = {{(DW-CLW){1'b0}}, clamp_lvl};

    always_comb begin
        if (blank && !clamp) sub = blank_sel ? lvl_ext : '0;
        else                 sub = data;
        value = gray ? (sub ^ (sub >> 1)) : sub;
    end
endmodule

// File: rtl/pix_formatter.sv
module pix_formatter
    import pxf_pkg::*;
#(
    parameter int DW  = 12,
    parameter int CLW = 8,
    parameter int LAT = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  smp_data,
    input  logic           dclk_in,
    input  logic           clamp_in,
    input  logic           blank_in,
    input  logic           cfg_pol_dclk,
    input  logic           cfg_pol_clamp,
    input  logic           cfg_pol_blank,
    input  logic           cfg_blank_sel,
    input  logic           cfg_gray,
    input  logic           cfg_transparent,
    input  logic           cfg_tristate,
    input  logic [CLW-1:0] cfg_clamp_lvl,
    output logic [DW-1:0]  pix_out,
    output logic           pix_oe
);
    localparam int STAGES = LAT - 1;

    logic [STB_COUNT-1:0] stb_raw, stb_pol, stb_act;
    logic [DW-1:0]        tail_data;
    logic                 tail_blank, tail_clamp;
    logic [DW-1:0]        fmt_val;
    logic [DW-1:0]        hold_q;
    drive_state_t         state, state_nxt;

    assign stb_raw[STB_DCLK]  = dclk_in;
    assign stb_raw[STB_CLAMP] = clamp_in;
    assign stb_raw[STB_BLANK] = blank_in;
    assign stb_pol[STB_DCLK]  = cfg_pol_dclk;
    assign stb_pol[STB_CLAMP] = cfg_pol_clamp;
    assign stb_pol[STB_BLANK] = cfg_pol_blank;

    pxf_strobe_pol #(.N(STB_COUNT)) u_pol (
        .raw (stb_raw),
        .pol (stb_pol),
        .act (stb_act)
    );

    pxf_delay #(.DW(DW), .STAGES(STAGES)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (smp_data),
        .in_blank  (stb_act[STB_BLANK]),
        .in_clamp  (stb_act[STB_CLAMP]),
        .out_data  (tail_data),
        .out_blank (tail_blank),
        .out_clamp (tail_clamp)
    );

    pxf_former #(.DW(DW), .CLW(CLW)) u_fmt (
        .data      (tail_data),
        .blank     (tail_blank),
        .clamp     (tail_clamp),
        .blank_sel (cfg_blank_sel),
        .gray      (cfg_gray),
        .clamp_lvl (cfg_clamp_lvl),
        .value     (fmt_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_q <= '0;
        else if (stb_act[STB_DCLK])  hold_q <= fmt_val;
    end

    // transitions T_TO_FLOAT, T_TO_PASS, T_TO_LATCH in priority order
    always_comb begin
        if (cfg_tristate)         state_nxt = S_FLOAT;
        else if (cfg_transparent) state_nxt = S_PASS;
        else                      state_nxt = S_LATCH;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_LATCH;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            S_LATCH: begin pix_oe = 1'b1; pix_out = hold_q;  end
            S_PASS:  begin pix_oe = 1'b1; pix_out = fmt_val; end
            S_FLOAT: begin pix_oe = 1'b0; pix_out = '0;      end
            default: begin pix_oe = 1'b0; pix_out = '0;      end
        endcase
    end
endmodule

// File: rtl/pxf_checker.sv
module pxf_checker #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_tristate,
    input logic          cfg_transparent,
    input logic          cfg_pol_dclk,
    input logic          dclk_in,
    input logic          cfg_gray,
    input logic          cfg_blank_sel,
    input logic [DW-1:0] pix_out,
    input logic          pix_oe,
    input logic [DW-1:0] tail_data,
    input logic          tail_blank,
    input logic          tail_clamp,
    input logic [DW-1:0] fmt_val
);
    logic lat_mode, dclk_act;
    assign lat_mode = !cfg_tristate && !cfg_transparent;
    assign dclk_act = (dclk_in == cfg_pol_dclk);

    p_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tristate |=> (!pix_oe && pix_out == '0));

    p_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tristate |=> pix_oe);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_mode && $past(lat_mode) && !dclk_act) |=> $stable(pix_out));

    p_blank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_blank && !tail_clamp && !cfg_blank_sel) |-> (fmt_val == '0));

    p_clamp_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_clamp && !cfg_gray) |-> (fmt_val == tail_data));
endmodule

bind pix_formatter pxf_checker #(.DW(DW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_tristate    (cfg_tristate),
    .cfg_transparent (cfg_transparent),
    .cfg_pol_dclk    (cfg_pol_dclk),
    .dclk_in         (dclk_in),
    .cfg_gray        (cfg_gray),
    .cfg_blank_sel   (cfg_blank_sel),
    .pix_out         (pix_out),
    .pix_oe          (pix_oe),
    .tail_data       (tail_data),
    .tail_blank      (tail_blank),
    .tail_clamp      (tail_clamp),
    .fmt_val         (fmt_val)
);

// File: tb/pix_formatter_bench.sv
module pix_formatter_bench;
    localparam int DW = 12;
    localparam int CLW = 8;
    localparam int NH = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic dclk_in = 1'b0, clamp_in = 1'b0, blank_in = 1'b0;
    logic pol_d = 1'b0, pol_c = 1'b0, pol_b = 1'b0;
    logic blank_sel = 1'b0, gray = 1'b0, transp = 1'b0, trist = 1'b0;
    logic [CLW-1:0] lvl = 8'd0;
    logic [DW-1:0] out_a, out_b;
    logic oe_a, oe_b;

    always #2.5 clk = ~clk;

    pix_formatter #(.DW(DW), .CLW(CLW), .LAT(10)) u_pix_formatter (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .dclk_in(dclk_in),
        .clamp_in(clamp_in), .blank_in(blank_in), .cfg_pol_dclk(pol_d),
        .cfg_pol_clamp(pol_c), .cfg_pol_blank(pol_b), .cfg_blank_sel(blank_sel),
        .cfg_gray(gray), .cfg_transparent(transp), .cfg_tristate(trist),
        .cfg_clamp_lvl(lvl), .pix_out(out_a), .pix_oe(oe_a));

    pix_formatter #(.DW(DW), .CLW(CLW), .LAT(2)) u_pix_formatter_l2 (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .dclk_in(dclk_in),
        .clamp_in(clamp_in), .blank_in(blank_in), .cfg_pol_dclk(pol_d),
        .cfg_pol_clamp(pol_c), .cfg_pol_blank(pol_b), .cfg_blank_sel(blank_sel),
        .cfg_gray(gray), .cfg_transparent(transp), .cfg_tristate(trist),
        .cfg_clamp_lvl(lvl), .pix_out(out_b), .pix_oe(oe_b));

    int total = 0;
    int bad = 0;
    int c = 0;
    string tag = "R2";
    int hd [NH];
    bit hb [NH];
    bit hc [NH];
    bit hk [NH];
    logic [DW-1:0] eh_a = '0, eh_b = '0;

    task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d: got %0h expected %0h", req, c, got, exp);
        end
    endtask

    // expected formatted value of history entry idx under the present settings
    function automatic logic [DW-1:0] fexp(int idx);
        int b;
        if (idx < 0) return '0;
        b = hd[idx];
        if (hb[idx] && !hc[idx]) b = blank_sel ? int'(lvl) : 0;
        if (gray) b = b ^ (b >> 1);
        return DW'(b);
    endfunction

    task automatic step(int data, bit d_act, bit c_act, bit b_act);
        logic [DW-1:0] ea, eb;
        string mt;
        smp_data = DW'(data);
        dclk_in  = d_act ? pol_d : ~pol_d;
        clamp_in = c_act ? pol_c : ~pol_c;
        blank_in = b_act ? pol_b : ~pol_b;
        hd[c] = data; hk[c] = d_act; hc[c] = c_act; hb[c] = b_act;
        @(posedge clk);
        if (hk[c]) begin
            eh_a = fexp(c - 9);
            eh_b = fexp(c - 1);
        end
        @(negedge clk);
        if (trist) begin
            ea = '0; eb = '0; mt = "R10";
        end else if (transp) begin
            ea = fexp(c - 8); eb = fexp(c); mt = "R3";
        end else begin
            ea = eh_a; eb = eh_b; mt = "R2";
        end
        chk({mt, "/", tag, " lat10 data"}, out_a, ea);
        chk({mt, "/", tag, " lat2 data"}, out_b, eb);
        chk({"R10/", tag, " lat10 oe"}, DW'(oe_a), DW'(!trist));
        chk({"R10/", tag, " lat2 oe"}, DW'(oe_b), DW'(!trist));
        c++;
    endtask

    initial begin
        #(5 * 50000);
        bad++; total++;
        $display("FAIL watchdog: got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 lat10 data", out_a, '0);
        chk("R1 lat10 oe", DW'(oe_a), DW'(1));
        chk("R1 lat2 data", out_b, '0);
        chk("R1 lat2 oe", DW'(oe_b), DW'(1));
        rst_n = 1'b1;

        tag = "R2";
        for (int i = 0; i < 30; i++) step(int'($urandom_range(0, 4095)), 1, 0, 0);
        tag = "R6";
        for (int i = 0; i < 30; i++) step(int'($urandom_range(1, 4095)), 1, 0, (i % 5) < 2);
        tag = "R7";
        blank_sel = 1'b1; lvl = 8'd200;
        for (int i = 0; i < 30; i++) step(int'($urandom_range(1, 4095)), 1, 0, (i % 4) == 1);
        tag = "R8";
        for (int i = 0; i < 30; i++) step(int'($urandom_range(1, 4095)), 1, (i % 3) == 0, (i % 2) == 0);
        tag = "R9";
        gray = 1'b1;
        for (int i = 0; i < 30; i++) step(int'($urandom_range(0, 4095)), 1, (i % 7) == 0, (i % 3) == 0);
        gray = 1'b0; blank_sel = 1'b0;
        tag = "R3";
        transp = 1'b1;
        for (int i = 0; i < 30; i++) step(int'($urandom_range(0, 4095)), 1, 0, (i % 6) == 2);
        tag = "R4";
        transp = 1'b0;
        for (int i = 0; i < 30; i++) step(int'($urandom_range(0, 4095)), (i % 3) == 0, 0, 0);
        tag = "R10";
        trist = 1'b1;
        for (int i = 0; i < 12; i++) step(int'($urandom_range(0, 4095)), 1, 0, 0);
        trist = 1'b0;
        tag = "R5";
        pol_d = 1'b1; pol_c = 1'b1; pol_b = 1'b1; blank_sel = 1'b1; lvl = 8'd77;
        for (int i = 0; i < 40; i++) step(int'($urandom_range(0, 4095)), (i % 4) != 3, (i % 9) == 0, (i % 3) == 0);
        pol_b = 1'b0;
        for (int i = 0; i < 20; i++) step(int'($urandom_range(0, 4095)), 1, 0, (i % 2) == 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule